// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer with Result Justification

This block is the digital controller for a 10-bit successive-approximation converter that serves up to eight analog channels. Software programs a small set of configuration fields: enable, trigger source, first and last channel of a scan, sampling length and result alignment. The block then waits for a trigger from the selected source. Once triggered, it walks upward through the channel range. For each channel it holds a sample-enable strobe for the programmed number of cycles and then allows a fixed eleven conversion cycles. At the end of that window it captures the converter's 10-bit output into a 16-bit result word.

The software start input and the busy readout behave as one register bit. Writing it launches a scan when software triggering is selected, and reading it returns 1 while any scan is running, whatever source started it. A current-channel readout follows the scan. A one-cycle done pulse marks every result write. Clearing enable ends a scan at once and discards the conversion in flight.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, busy, sample enable and done are 0, the result is 0x0000 and the current channel is 0.
- R2: With the alignment bit at 1, a result write puts the 10-bit conversion value in bits 15..6 and zeros in bits 5..0.
- R3: With the alignment bit at 0, a result write puts the 10-bit conversion value in bits 9..0 and zeros in bits 15..10.
- R4: While enable is 0, no trigger from any source starts a scan and busy stays 0.
- R5: The 2-bit source select decides which input can start a scan. Code 0 selects the software start input, and codes 1, 2 and 3 select hardware trigger inputs 0, 1 and 2. A pulse on any source that is not selected has no effect.
- R6: Busy reads 1 from the cycle after a trigger is accepted until the last result of the scan is written, for every trigger source.
- R7: For each channel, sample enable is high for exactly 3 + 2 × setting cycles, where setting is the 3-bit sampling field. Eleven conversion cycles follow, so one channel takes 14 + 2 × setting cycles from the start of sampling to its result write.
- R8: A scan converts the channels from the first channel up to the last channel in ascending order, and the current-channel output shows the channel being converted. If the last channel is at or below the first channel, only the first channel is converted.
- R9: Done is high for exactly one cycle, in the cycle the result register shows the new value, once per converted channel.
- R10: A trigger that arrives while a scan is running is ignored. It neither restarts nor extends the scan.
- R11: If enable drops during a scan, busy and sample enable clear on the next cycle, and neither a result write nor a done pulse follows. This holds even when enable drops in the final conversion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Block enable |
| cfg_tsel_i | input | 2 | Trigger source select (0 = software, 1..3 = hardware input 0..2) |
| cfg_first_ch_i | input | 3 | First channel of a scan |
| cfg_last_ch_i | input | 3 | Last channel of a scan |
| cfg_smp_set_i | input | 3 | Sampling length setting |
| cfg_left_i | input | 1 | Alignment: 1 = high-order, 0 = low-order |
| sw_start_i | input | 1 | Software start write pulse |
| hw_trig_i | input | 3 | Hardware trigger inputs |
| conv_data_i | input | 10 | Converter output value |
| busy_o | output | 1 | Scan in progress (software start readback) |
| cur_ch_o | output | 3 | Channel currently being converted |
| sample_en_o | output | 1 | Sampling strobe to the analog macro |
| result_o | output | 16 | Aligned conversion result |
| done_o | output | 1 | One-cycle pulse per result write |

## Verification
The most delicate collision is between the final conversion edge, which writes the result and raises done, and the loss of enable, which must abort the scan. The bench drops enable exactly in the last conversion cycle of a channel. It expects busy to fall with no done pulse and the result word to keep its previous value, so a write-before-abort ordering is caught. A second overlap places a fresh software trigger in the middle of a running scan. The bench judges it by done arriving on the original schedule and busy staying low afterwards.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SMP  = 2'd1,
    PH_CNV  = 2'd2
  } phase_e;
endpackage

// File: rtl/adc_phase_timer.sv
// Shared cycle counter for the sampling and conversion phases.
module adc_phase_timer #(
  parameter int SET_W    = 3,
  parameter int SMP_BASE = 3,
  parameter int SMP_STEP = 2,
  parameter int CONV_CYC = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             in_smp,
  input  logic [SET_W-1:0] smp_set,
  output logic             phase_end
);
  localparam int SMP_MAX = SMP_BASE + SMP_STEP * ((1 << SET_W) - 1);
  localparam int LIM_MAX = (SMP_MAX > CONV_CYC) ? SMP_MAX : CONV_CYC;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    if (in_smp) lim = CNT_W'(SMP_BASE) + CNT_W'(SMP_STEP) * CNT_W'(smp_set) - CNT_W'(1);
    else        lim = CNT_W'(CONV_CYC - 1);
  end

  assign phase_end = (cnt_q == lim);

  always_comb begin
    if (run) cnt_d = cnt_q + CNT_W'(1);
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_trig_mux.sv
// Selects one start source; source 0 is the software start.
module adc_trig_mux #(
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0]          sel,
  input  logic                      sw_start,
  input  logic [(1 << SEL_W)-2:0]   hw_trig,
  output logic                      fire
);
  localparam int NSRC = 1 << SEL_W;

  logic [NSRC-1:0] src;

  assign src[0] = sw_start;
  for (genvar g = 0; g < NSRC - 1; g++) begin : g_hw
    assign src[g+1] = hw_trig[g];
  end

  assign fire = src[sel];
endmodule

// File: rtl/adc_result_fmt.sv
// Aligns the conversion value and holds it in the result register.
module adc_result_fmt #(
  parameter int DATA_W = 10,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              left,
  input  logic [DATA_W-1:0] data,
  output logic [RES_W-1:0]  result
);
  localparam int PAD_W = RES_W - DATA_W;

  logic [RES_W-1:0] res_d, res_q;

  always_comb begin
    res_d = res_q;
    if (wr) begin
      if (left) res_d = {data, {PAD_W{1'b0}}};
      else      res_d = {{PAD_W{1'b0}}, data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign result = res_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int SET_W    = 3,
  parameter int TSEL_W   = 2,
  parameter int DATA_W   = 10,
  parameter int RES_W    = 16,
  parameter int SMP_BASE = 3,
  parameter int SMP_STEP = 2,
  parameter int CONV_CYC = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_en_i,
  input  logic [TSEL_W-1:0]        cfg_tsel_i,
  input  logic [CH_W-1:0]          cfg_first_ch_i,
  input  logic [CH_W-1:0]          cfg_last_ch_i,
  input  logic [SET_W-1:0]         cfg_smp_set_i,
  input  logic                     cfg_left_i,
  input  logic                     sw_start_i,
  input  logic [(1 << TSEL_W)-2:0] hw_trig_i,
  input  logic [DATA_W-1:0]        conv_data_i,
  output logic                     busy_o,
  output logic [CH_W-1:0]          cur_ch_o,
  output logic                     sample_en_o,
  output logic [RES_W-1:0]         result_o,
  output logic                     done_o
);
  phase_e          state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            done_q;
  logic            fire, phase_end, run, wr;

  adc_trig_mux #(.SEL_W(TSEL_W)) u_trig (
    .sel      (cfg_tsel_i),
    .sw_start (sw_start_i),
    .hw_trig  (hw_trig_i),
    .fire     (fire)
  );

  adc_phase_timer #(
    .SET_W(SET_W), .SMP_BASE(SMP_BASE), .SMP_STEP(SMP_STEP), .CONV_CYC(CONV_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .in_smp    (state_q == PH_SMP),
    .smp_set   (cfg_smp_set_i),
    .phase_end (phase_end)
  );

  adc_result_fmt #(.DATA_W(DATA_W), .RES_W(RES_W)) u_fmt (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr),
    .left   (cfg_left_i),
    .data   (conv_data_i),
    .result (result_o)
  );

  // Next-state logic: abort on loss of enable outranks the result write.
  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    wr      = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (cfg_en_i && fire) begin
          state_d = PH_SMP;
          ch_d    = cfg_first_ch_i;
        end
      end
      PH_SMP: begin
        if (!cfg_en_i)      state_d = PH_IDLE;
        else if (phase_end) state_d = PH_CNV;
      end
      PH_CNV: begin
        if (!cfg_en_i) begin
          state_d = PH_IDLE;
        end else if (phase_end) begin
          wr = 1'b1;
          if (ch_q >= cfg_last_ch_i) begin
            state_d = PH_IDLE;
          end else begin
            ch_d    = ch_q + CH_W'(1);
            state_d = PH_SMP;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  assign run = (state_q != PH_IDLE) && (state_d == state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      ch_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      done_q  <= wr;
    end
  end

  assign busy_o      = (state_q != PH_IDLE);
  assign sample_en_o = (state_q == PH_SMP);
  assign cur_ch_o    = ch_q;
  assign done_o      = done_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_W     = 3,
  parameter int SET_W    = 3,
  parameter int DATA_W   = 10,
  parameter int RES_W    = 16,
  parameter int SMP_BASE = 3,
  parameter int SMP_STEP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en_i,
  input logic             cfg_left_i,
  input logic [SET_W-1:0] cfg_smp_set_i,
  input logic             busy_o,
  input logic             sample_en_o,
  input logic             done_o,
  input logic [CH_W-1:0]  cur_ch_o,
  input logic [RES_W-1:0] result_o
);
  logic [7:0] smp_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           smp_run <= '0;
    else if (sample_en_o) smp_run <= smp_run + 8'd1;
    else                  smp_run <= '0;
  end

  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !cfg_en_i) |=> !busy_o);

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cfg_en_i) |=> (!busy_o && !done_o));

  assert_fill_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(cfg_left_i)) |-> (result_o[RES_W-DATA_W-1:0] == '0));

  assert_fill_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(cfg_left_i)) |-> (result_o[RES_W-1:DATA_W] == '0));

  assert_sample_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_en_o) && busy_o) |->
      (smp_run == 8'(SMP_BASE) + 8'(SMP_STEP) * 8'(cfg_smp_set_i)));

  assert_busy_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> busy_o);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_ascend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (cur_ch_o >= $past(cur_ch_o)));

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en_o && $past(sample_en_o)) |-> $stable(cur_ch_o));
endmodule

bind adc_seq_ctrl adc_seq_chk #(
  .CH_W(CH_W), .SET_W(SET_W), .DATA_W(DATA_W), .RES_W(RES_W),
  .SMP_BASE(SMP_BASE), .SMP_STEP(SMP_STEP)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_en_i      (cfg_en_i),
  .cfg_left_i    (cfg_left_i),
  .cfg_smp_set_i (cfg_smp_set_i),
  .busy_o        (busy_o),
  .sample_en_o   (sample_en_o),
  .done_o        (done_o),
  .cur_ch_o      (cur_ch_o),
  .result_o      (result_o)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en;
  logic [1:0]  cfg_tsel;
  logic [2:0]  cfg_first, cfg_last, cfg_set;
  logic        cfg_left;
  logic        sw_start;
  logic [2:0]  hw_trig;
  logic [9:0]  base_r;
  logic [9:0]  conv_data;
  logic        busy, smp_en, done;
  logic [2:0]  cur_ch;
  logic [15:0] result;

  int          total_chk = 0;
  int          bad_chk   = 0;
  bit          finished  = 1'b0;
  logic [15:0] last_res  = '0;

  always #10 clk = ~clk;

  assign conv_data = base_r ^ {cur_ch, 7'h15};

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_en_i(cfg_en), .cfg_tsel_i(cfg_tsel),
    .cfg_first_ch_i(cfg_first), .cfg_last_ch_i(cfg_last), .cfg_smp_set_i(cfg_set),
    .cfg_left_i(cfg_left), .sw_start_i(sw_start), .hw_trig_i(hw_trig),
    .conv_data_i(conv_data), .busy_o(busy), .cur_ch_o(cur_ch),
    .sample_en_o(smp_en), .result_o(result), .done_o(done)
  );

  // fields: sel[21:20] first[19:17] last[16:14] set[13:11] left[10] base[9:0]
  localparam logic [21:0] VEC [6] = '{
    {2'd0, 3'd0, 3'd2, 3'd0, 1'b1, 10'h3A5},
    {2'd1, 3'd3, 3'd3, 3'd7, 1'b0, 10'h155},
    {2'd2, 3'd5, 3'd7, 3'd2, 1'b1, 10'h0F0},
    {2'd3, 3'd6, 3'd1, 3'd1, 1'b0, 10'h2CC},
    {2'd0, 3'd0, 3'd7, 3'd3, 1'b0, 10'h1E1},
    {2'd1, 3'd2, 3'd4, 3'd5, 1'b1, 10'h3FF}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] fmt(input bit left, input logic [9:0] d);
    return left ? {d, 6'b0} : {6'b0, d};
  endfunction

  task automatic set_src(input int sel, input bit v);
    if (sel == 0) sw_start = v;
    else          hw_trig[sel-1] = v;
  endtask

  task automatic run_scan(input int sel, input int first, input int last_c, input int set,
                          input bit left, input logic [9:0] base,
                          input int abort_at, input int retrig_at);
    int  nch, len, nsmp, total;
    bit  ab, eb, es, ed;
    nch   = (last_c >= first) ? (last_c - first + 1) : 1;
    len   = 14 + 2 * set;
    nsmp  = 3 + 2 * set;
    total = nch * len;
    @(negedge clk);
    cfg_en = 1'b0; cfg_tsel = 2'(sel); cfg_first = 3'(first); cfg_last = 3'(last_c);
    cfg_set = 3'(set); cfg_left = left; base_r = base;
    @(negedge clk);
    cfg_en = 1'b1;
    @(negedge clk);
    set_src(sel, 1'b1);
    for (int i = 0; i <= total + 2; i++) begin
      @(negedge clk);
      if (i == 0) set_src(sel, 1'b0);
      ab = (abort_at >= 0) && (i > abort_at);
      eb = !ab && (i < total);
      es = eb && ((i % len) < nsmp);
      ed = !ab && (i > 0) && ((i % len) == 0) && (i <= total);
      if (ed) last_res = fmt(left, base ^ {3'(first + i / len - 1), 7'h15});
      chk(busy == eb, ab ? "R11 busy" : "R6 busy", 32'(busy), 32'(eb));
      chk(smp_en == es, ab ? "R11 sample" : "R7 sample", 32'(smp_en), 32'(es));
      chk(done == ed, ab ? "R11 done" : "R9 done", 32'(done), 32'(ed));
      chk(result == last_res, ab ? "R11 result" : (left ? "R2 result" : "R3 result"),
          32'(result), 32'(last_res));
      if (eb) chk(cur_ch == 3'(first + i / len), "R8 channel", 32'(cur_ch), 32'(3'(first + i / len)));
      if (i == retrig_at)     sw_start = 1'b1;
      if (i == retrig_at + 1) sw_start = 1'b0;
      if (i == abort_at)      cfg_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad_chk++;
      total_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_tsel = '0; cfg_first = '0; cfg_last = '0;
    cfg_set = '0; cfg_left = 1'b0; sw_start = 1'b0; hw_trig = '0; base_r = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !smp_en && !done, "R1 flags in reset", {busy, smp_en, done}, 0);
    chk(result == 16'h0 && cur_ch == 3'd0, "R1 result/channel in reset", {result, cur_ch}, 0);
    @(posedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !smp_en && !done, "R1 flags after reset", {busy, smp_en, done}, 0);
    chk(result == 16'h0, "R1 result after reset", 32'(result), 0);

    // Vector walk: R2 R3 R5 R6 R7 R8 R9
    for (int v = 0; v < 6; v++)
      run_scan(int'(VEC[v][21:20]), int'(VEC[v][19:17]), int'(VEC[v][16:14]),
               int'(VEC[v][13:11]), VEC[v][10], VEC[v][9:0], -1, -1);

    // R4: enable low, software trigger ignored
    @(negedge clk); cfg_en = 1'b0; cfg_tsel = 2'd0; sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy, "R4 trigger with enable low", 32'(busy), 0);
    end

    // R5: hardware input 1 selected; other sources ignored
    @(negedge clk); cfg_en = 1'b1; cfg_tsel = 2'd2; sw_start = 1'b1; hw_trig = 3'b101;
    @(negedge clk); sw_start = 1'b0; hw_trig = 3'b000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy, "R5 unselected source", 32'(busy), 0);
    end
    hw_trig = 3'b010;
    @(negedge clk); hw_trig = 3'b000;
    chk(busy, "R5 selected source starts", 32'(busy), 1);
    cfg_en = 1'b0;
    @(negedge clk);
    chk(!busy, "R11 abort from sampling", 32'(busy), 0);

    // R10: retrigger mid-scan ignored
    run_scan(0, 4, 4, 0, 1'b0, 10'h2B7, -1, 5);
    // R11: abort in the last conversion cycle (collides with the write)
    run_scan(0, 1, 1, 0, 1'b1, 10'h111, 13, -1);
    // R11: abort during sampling
    run_scan(0, 2, 3, 4, 1'b0, 10'h0AA, 2, -1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule